// File: doc/BRIEF.md
# External Bus Beat Sequencer

The sequencer takes one internal access of 1, 2, 4 or 16 bytes and splits it into the beats needed on an external bus. The port behind the current chip select may be 8, 16 or 32 bits wide. For each beat the block drives an address, a two-bit transfer-size code, an active-low burst flag, a one-clock start strobe and the write data lanes. It also collects read data from each beat into one full-width word. A separate acknowledge block supplies one `ext_ack` pulse per finished beat, so that block decides all wait states.

The request side is a simple valid/ready pair, with a per-chip-select burst enable sampled with the request. In burst mode the size code shows the whole transfer on every beat and the start strobe fires only once. With bursting inhibited, every beat gets its own strobe, and from the second beat on the size code reports the port width. A 16-byte transfer that starts off its 16-byte boundary wraps its beat addresses inside that boundary. When the last beat is acknowledged, a one-clock `rsp_done` pulse follows, and it carries the assembled read word.

Top module: `xbus_beat_seq`

## Requirements
- R1: While reset is held and right after it: `req_ready`=1, `ext_start`=0, `ext_burst_n`=1, `rsp_done`=0.
- R2: The beat count is the transfer bytes divided by the port bytes, with a minimum of one. `rsp_done` follows only after that many `ext_ack` beats.
- R3: When the burst enable is set and more than one beat is needed: `ext_burst_n`=0 for every beat, and `ext_size` carries the whole-transfer code on every beat.
- R4: When the burst enable is clear: `ext_burst_n`=1. `ext_size` carries the whole-transfer code on the first beat and the port-width code on each later beat.
- R5: Size codes are 01=1 byte, 10=2 bytes, 00=4 bytes, 11=16 bytes. The `req_port` encoding is 0=8-bit, 1=16-bit, 2=32-bit. The port-width code of an 8/16/32-bit port is 01/10/00.
- R6: `ext_start` is high for exactly one clock. It appears in the cycle after a request is accepted and, in non-burst mode only, in the cycle after each non-final `ext_ack`. It is low in all other cycles.
- R7: Beat n is addressed at the start address plus n times the beat width in bytes. For 16-byte transfers, address bits [3:0] wrap modulo 16 and the upper bits stay fixed.
- R8: A transfer no wider than the port takes one beat with `ext_burst_n`=1, even with the burst enable set.
- R9: On a write, beat n drives, low-justified on `ext_wdata`, the bytes of `req_wdata` starting at byte n times the beat width. Lanes beyond the beat width are zero.
- R10: The cycle after the final `ext_ack`, `rsp_done` is high for one clock. In that cycle `rsp_rdata` holds each beat's low beat-width bytes of `ext_rdata`, placed at byte n times the beat width.
- R11: `req_valid` is ignored while `req_ready`=0. A request presented during a transfer neither starts a transfer nor changes the beats in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 2 | Transfer size code (R5) |
| req_port | input | 2 | Port width select (R5) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst enable for the selected chip select |
| req_wdata | input | 8*LINE_B | Write data, byte 0 in bits [7:0] |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8*LINE_B | Assembled read data |
| ext_addr | output | ADDR_W | Beat address |
| ext_size | output | 2 | Transfer-size code on the bus |
| ext_burst_n | output | 1 | Active-low burst-in-progress flag |
| ext_start | output | 1 | Beat start strobe |
| ext_write | output | 1 | Direction of the current transfer |
| ext_wdata | output | BUS_W | Write data lanes of the current beat |
| ext_rdata | input | BUS_W | Read data lanes from the port |
| ext_ack | input | 1 | Beat finished |

## Verification
The bench runs a 32-bit write to an 8-bit port both with and without bursting. This separates a design that holds the whole-transfer size code for every beat in both modes from one that switches to the port code after beat 0, and it catches start strobes repeated inside a burst. Misaligned 16-byte transfers show whether the address wraps at the 16-byte line or runs linearly into the next line. A transfer that fits in one beat with the burst enable set catches a design that drops `ext_burst_n` for a single beat. Acknowledges arrive both in the start cycle and after waits, and stray requests are presented mid-transfer. These expose a beat counter that advances without an acknowledge, read bytes placed at the wrong offset, and requests accepted while busy.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

   typedef enum logic [1:0] {
      SZ_WORD = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_HALF = 2'b10,
      SZ_LINE = 2'b11
   } xbs_size_e;

   typedef enum logic [1:0] {
      PW_8    = 2'd0,
      PW_16   = 2'd1,
      PW_32   = 2'd2,
      PW_RSVD = 2'd3
   } xbs_port_e;

   // bytes moved by a whole transfer
   function automatic logic [4:0] size_bytes(input logic [1:0] s);
      case (s)
         SZ_BYTE: return 5'd1;
         SZ_HALF: return 5'd2;
         SZ_WORD: return 5'd4;
         default: return 5'd16;
      endcase
   endfunction

   // bytes carried by the port; reserved encoding behaves as 32-bit
   function automatic logic [2:0] port_bytes(input logic [1:0] p);
      case (p)
         PW_8:    return 3'd1;
         PW_16:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // size code that names the port width on later non-burst beats
   function automatic logic [1:0] port_code(input logic [1:0] p);
      case (p)
         PW_8:    return SZ_BYTE;
         PW_16:   return SZ_HALF;
         default: return SZ_WORD;
      endcase
   endfunction

   // bytes moved per beat: the smaller of transfer and port
   function automatic logic [2:0] beat_bytes(input logic [1:0] s, input logic [1:0] p);
      logic [4:0] sb;
      logic [4:0] pb;
      sb = size_bytes(s);
      pb = {2'b00, port_bytes(p)};
      return (sb < pb) ? sb[2:0] : pb[2:0];
   endfunction

   // number of beats minus one
   function automatic logic [3:0] beats_m1(input logic [1:0] s, input logic [1:0] p);
      logic [4:0] n;
      case (p)
         PW_8:    n = size_bytes(s);
         PW_16:   n = size_bytes(s) >> 1;
         default: n = size_bytes(s) >> 2;
      endcase
      if (n <= 5'd1) return 4'd0;
      return 4'(n - 5'd1);
   endfunction

endpackage

// File: rtl/xbs_ctrl.sv
module xbs_ctrl #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [IDX_W-1:0] beats_m1,
   input  logic             burst_req,
   input  logic             beat_ack,
   output logic             req_ready,
   output logic             accept,
   output logic             active,
   output logic             burst_on,
   output logic             start,
   output logic             done,
   output logic             capture,
   output logic [IDX_W-1:0] beat_idx
);

   logic [IDX_W-1:0] last_q;

   assign req_ready = !active;
   assign accept    = req_valid && !active;
   assign capture   = active && beat_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         burst_on <= 1'b0;
         start    <= 1'b0;
         done     <= 1'b0;
         beat_idx <= '0;
         last_q   <= '0;
      end else begin
         start <= 1'b0;
         done  <= 1'b0;
         if (accept) begin
            active   <= 1'b1;
            beat_idx <= '0;
            last_q   <= beats_m1;
            burst_on <= burst_req && (beats_m1 != '0);
            start    <= 1'b1;
         end else if (capture) begin
            if (beat_idx == last_q) begin
               active   <= 1'b0;
               burst_on <= 1'b0;
               done     <= 1'b1;
            end else begin
               beat_idx <= beat_idx + 1'b1;
               start    <= !burst_on;
            end
         end
      end
   end

endmodule

// File: rtl/xbs_addr_gen.sv
module xbs_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int LINE_B    = 16,
   parameter bit LINE_WRAP = 1'b1,
   localparam int OFF_W    = $clog2(LINE_B),
   localparam int IDX_W    = $clog2(LINE_B)
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [1:0]        size,
   input  logic [2:0]        bbytes,
   input  logic [IDX_W-1:0]  beat_idx,
   output logic [ADDR_W-1:0] addr,
   output logic [OFF_W-1:0]  byte_off
);

   logic [6:0]        off_full;
   logic [ADDR_W-1:0] lin_addr;
   logic [ADDR_W-1:0] line_addr;

   assign off_full = 7'(beat_idx) * 7'(bbytes);
   assign byte_off = off_full[OFF_W-1:0];
   assign lin_addr = base + ADDR_W'(off_full);

   generate
      if (LINE_WRAP) begin : g_wrap
         assign line_addr = {base[ADDR_W-1:OFF_W], base[OFF_W-1:0] + byte_off};
      end else begin : g_linear
         assign line_addr = lin_addr;
      end
   endgenerate

   assign addr = (size == xbs_pkg::SZ_LINE) ? line_addr : lin_addr;

endmodule

// File: rtl/xbs_data_path.sv
module xbs_data_path #(
   parameter int BUS_W  = 32,
   parameter int LINE_B = 16,
   localparam int BUS_B  = BUS_W / 8,
   localparam int LINE_W = LINE_B * 8,
   localparam int OFF_W  = $clog2(LINE_B)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic [OFF_W-1:0]  byte_off,
   input  logic [2:0]        bbytes,
   input  logic [LINE_W-1:0] wdata_line,
   input  logic [BUS_W-1:0]  ext_rdata,
   output logic [BUS_W-1:0]  ext_wdata,
   output logic [LINE_W-1:0] rdata_line
);

   logic [BUS_W-1:0]   lane_mask;
   logic [OFF_W+2:0]   bit_sh;

   generate
      for (genvar g = 0; g < BUS_B; g++) begin : g_lane
         assign lane_mask[g*8 +: 8] = {8{(4'(g) < {1'b0, bbytes})}};
      end
   endgenerate

   assign bit_sh    = {byte_off, 3'b000};
   assign ext_wdata = BUS_W'(wdata_line >> bit_sh) & lane_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_line <= '0;
      end else if (clear) begin
         rdata_line <= '0;
      end else if (capture) begin
         rdata_line <= rdata_line | (LINE_W'(ext_rdata & lane_mask) << bit_sh);
      end
   end

endmodule

// File: rtl/xbus_beat_seq.sv
module xbus_beat_seq #(
   parameter int ADDR_W    = 32,
   parameter int BUS_W     = 32,
   parameter int LINE_B    = 16,
   parameter bit LINE_WRAP = 1'b1,
   localparam int LINE_W   = LINE_B * 8,
   localparam int IDX_W    = $clog2(LINE_B),
   localparam int OFF_W    = $clog2(LINE_B)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [1:0]        req_port,
   input  logic              req_write,
   input  logic              req_burst,
   input  logic [LINE_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [LINE_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [1:0]        ext_size,
   output logic              ext_burst_n,
   output logic              ext_start,
   output logic              ext_write,
   output logic [BUS_W-1:0]  ext_wdata,
   input  logic [BUS_W-1:0]  ext_rdata,
   input  logic              ext_ack
);
   import xbs_pkg::*;

   generate
      if (BUS_W != 32) begin : g_bad_bus
         $error("xbus_beat_seq: BUS_W must be 32");
      end
      if (LINE_B != 16) begin : g_bad_line
         $error("xbus_beat_seq: LINE_B must be 16");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("xbus_beat_seq: ADDR_W too small");
      end
   endgenerate

   logic              accept;
   logic              active;
   logic              burst_on;
   logic              capture;
   logic [IDX_W-1:0]  beat_idx;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        size_q;
   logic [1:0]        port_q;
   logic              write_q;
   logic [LINE_W-1:0] wdata_q;
   logic [2:0]        bbytes;
   logic [OFF_W-1:0]  byte_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         size_q  <= SZ_WORD;
         port_q  <= PW_32;
         write_q <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         base_q  <= req_addr;
         size_q  <= req_size;
         port_q  <= req_port;
         write_q <= req_write;
         wdata_q <= req_wdata;
      end
   end

   assign bbytes = beat_bytes(size_q, port_q);

   xbs_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .beats_m1  (IDX_W'(beats_m1(req_size, req_port))),
      .burst_req (req_burst),
      .beat_ack  (ext_ack),
      .req_ready (req_ready),
      .accept    (accept),
      .active    (active),
      .burst_on  (burst_on),
      .start     (ext_start),
      .done      (rsp_done),
      .capture   (capture),
      .beat_idx  (beat_idx)
   );

   xbs_addr_gen #(
      .ADDR_W    (ADDR_W),
      .LINE_B    (LINE_B),
      .LINE_WRAP (LINE_WRAP)
   ) u_addr (
      .base     (base_q),
      .size     (size_q),
      .bbytes   (bbytes),
      .beat_idx (beat_idx),
      .addr     (ext_addr),
      .byte_off (byte_off)
   );

   xbs_data_path #(
      .BUS_W  (BUS_W),
      .LINE_B (LINE_B)
   ) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .capture    (capture),
      .byte_off   (byte_off),
      .bbytes     (bbytes),
      .wdata_line (wdata_q),
      .ext_rdata  (ext_rdata),
      .ext_wdata  (ext_wdata),
      .rdata_line (rsp_rdata)
   );

   assign ext_write   = active && write_q;
   assign ext_burst_n = !(active && burst_on);
   assign ext_size    = !active                        ? SZ_WORD :
                        (burst_on || beat_idx == '0)   ? size_q  :
                                                         port_code(port_q);

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              ext_start,
   input logic              ext_burst_n,
   input logic [1:0]        ext_size,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [ADDR_W-1:0] base_q,
   input logic [1:0]        size_q,
   input logic [1:0]        port_q,
   input logic [IDX_W-1:0]  beat_idx
);
   import xbs_pkg::*;

   // R6: a strobe only occurs inside a transfer
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_start |-> !req_ready);

   // R6: once a burst is running, no further strobe until it ends
   assert_burst_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_burst_n |=> (ext_burst_n || !ext_start));

   // R3: the size code is held across a burst
   assert_burst_size_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_burst_n && !ext_start) |-> $stable(ext_size));

   // R4: later non-burst beats carry the port code
   assert_later_beat_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && ext_burst_n && beat_idx != '0) |-> (ext_size == port_code(port_q)));

   // R7: a 16-byte transfer never leaves its line
   assert_line_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && size_q == SZ_LINE) |-> (ext_addr[ADDR_W-1:4] == base_q[ADDR_W-1:4]));

   // R10: completion is a single-cycle pulse
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R10: the block is idle when it reports completion
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

endmodule

bind xbus_beat_seq xbs_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .ext_start   (ext_start),
   .ext_burst_n (ext_burst_n),
   .ext_size    (ext_size),
   .rsp_done    (rsp_done),
   .ext_addr    (ext_addr),
   .base_q      (base_q),
   .size_q      (size_q),
   .port_q      (port_q),
   .beat_idx    (beat_idx)
);

// File: tb/sim_xbus_beat_seq.sv
module sim_xbus_beat_seq;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid;
   logic         req_ready;
   logic [31:0]  req_addr;
   logic [1:0]   req_size;
   logic [1:0]   req_port;
   logic         req_write;
   logic         req_burst;
   logic [127:0] req_wdata;
   logic         rsp_done;
   logic [127:0] rsp_rdata;
   logic [31:0]  ext_addr;
   logic [1:0]   ext_size;
   logic         ext_burst_n;
   logic         ext_start;
   logic         ext_write;
   logic [31:0]  ext_wdata;
   logic [31:0]  ext_rdata;
   logic         ext_ack;

   always #2.5 clk = ~clk;

   xbus_beat_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_port(req_port),
      .req_write(req_write), .req_burst(req_burst), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr),
      .ext_size(ext_size), .ext_burst_n(ext_burst_n), .ext_start(ext_start),
      .ext_write(ext_write), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ext_ack(ext_ack)
   );

   typedef struct {
      logic [31:0] addr;
      logic [1:0]  tsz;
      logic        bn;
      logic        st;
      logic [31:0] wd;
      logic [31:0] rd;
      bit          wr;
      bit          last;
      bit          first;
      int          waitc;
   } beat_t;

   beat_t        exp_q[$];
   logic [127:0] exp_rd;
   bit           exp_isrd;
   int           n_chk  = 0;
   int           n_fail = 0;
   int           done_cnt = 0;
   bit           junk_en = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // encodings taken from R5
   function automatic int sz_b(input logic [1:0] s);
      case (s)
         2'b01:   return 1;
         2'b10:   return 2;
         2'b00:   return 4;
         default: return 16;
      endcase
   endfunction

   function automatic int pt_b(input logic [1:0] p);
      case (p)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

   function automatic logic [1:0] pcode(input logic [1:0] p);
      case (p)
         2'd0:    return 2'b01;
         2'd1:    return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   task automatic run(input logic [31:0] a, input logic [1:0] s, input logic [1:0] p,
                      input bit wr, input bit bst, input logic [127:0] wd, input bit junk);
      int sb, pb, bb, nb, target;
      bit beff;
      logic [31:0] m;
      logic [127:0] acc;
      sb = sz_b(s);
      pb = pt_b(p);
      bb = (sb < pb) ? sb : pb;
      nb = (sb > pb) ? sb / pb : 1;
      beff = bst && (nb > 1);
      m = (bb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (bb * 8)) - 32'h1);
      acc = '0;
      for (int n = 0; n < nb; n++) begin
         beat_t b;
         logic [31:0] off;
         off = 32'(n * bb);
         b.addr  = (s == 2'b11) ? {a[31:4], 4'(a[3:0] + off[3:0])} : a + off;
         b.tsz   = (beff || n == 0) ? s : pcode(p);
         b.bn    = !beff;
         b.st    = (n == 0) || !beff;
         b.wd    = 32'(wd >> (n * bb * 8)) & m;
         b.rd    = 32'h5A3C_96E1 ^ (32'(n) * 32'h0103_0507) ^ a;
         b.wr    = wr;
         b.last  = (n == nb - 1);
         b.first = (n == 0);
         b.waitc = (n * 7 + int'(a[3:0])) % 3;
         acc = acc | (128'(b.rd & m) << (n * bb * 8));
         exp_q.push_back(b);
      end
      exp_rd   = acc;
      exp_isrd = !wr;
      target   = done_cnt + 1;
      @(negedge clk);
      req_addr  = a;
      req_size  = s;
      req_port  = p;
      req_write = wr;
      req_burst = bst;
      req_wdata = wd;
      req_valid = 1'b1;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      junk_en   = junk;
      req_addr  = 32'hDEAD_0000;
      req_size  = 2'b11;
      req_port  = 2'd0;
      req_write = ~wr;
      req_burst = ~bst;
      req_wdata = ~wd;
      wait (done_cnt == target);
      junk_en = 1'b0;
      @(negedge clk);
   endtask

   // monitor and beat responder
   initial begin
      ext_ack   = 1'b0;
      ext_rdata = '0;
      forever begin
         @(negedge clk);
         if (rst_n && !req_ready) begin
            forever begin
               beat_t b;
               int w;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R11 unexpected transfer", 128'(ext_addr), 128'h0);
                  break;
               end
               b = exp_q.pop_front();
               chk(ext_addr == b.addr, "R7 beat address", 128'(ext_addr), 128'(b.addr));
               chk(ext_size == b.tsz, b.first ? "R5 first size code" : (b.bn ? "R4 later size code" : "R3 burst size code"),
                   128'(ext_size), 128'(b.tsz));
               chk(ext_burst_n == b.bn, b.bn ? "R8 burst flag" : "R3 burst flag", 128'(ext_burst_n), 128'(b.bn));
               chk(ext_start == b.st, "R6 start strobe", 128'(ext_start), 128'(b.st));
               chk(ext_write == b.wr, "R9 direction", 128'(ext_write), 128'(b.wr));
               if (b.wr) chk(ext_wdata == b.wd, "R9 write lanes", 128'(ext_wdata), 128'(b.wd));
               w = b.waitc;
               while (w > 0) begin
                  ext_ack   = 1'b0;
                  req_valid = junk_en;
                  @(negedge clk);
                  chk(ext_start == 1'b0, "R6 no strobe while waiting", 128'(ext_start), 128'h0);
                  w--;
               end
               ext_ack   = 1'b1;
               ext_rdata = b.rd;
               req_valid = junk_en;
               @(negedge clk);
               ext_ack = 1'b0;
               if (b.last) begin
                  req_valid = 1'b0;
                  chk(rsp_done == 1'b1, "R2 done after final beat", 128'(rsp_done), 128'h1);
                  if (exp_isrd) chk(rsp_rdata == exp_rd, "R10 read assembly", rsp_rdata, exp_rd);
                  @(negedge clk);
                  chk(rsp_done == 1'b0, "R10 done one cycle", 128'(rsp_done), 128'h0);
                  chk(req_ready == 1'b1, "R11 idle after done", 128'(req_ready), 128'h1);
                  done_cnt++;
                  break;
               end else begin
                  chk(rsp_done == 1'b0, "R2 no early done", 128'(rsp_done), 128'h0);
               end
            end
         end
      end
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [127:0] pat;
      pat = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_size  = '0;
      req_port  = '0;
      req_write = 1'b0;
      req_burst = 1'b0;
      req_wdata = '0;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready in reset", 128'(req_ready), 128'h1);
      chk(ext_start == 1'b0, "R1 strobe in reset", 128'(ext_start), 128'h0);
      chk(ext_burst_n == 1'b1, "R1 burst flag in reset", 128'(ext_burst_n), 128'h1);
      chk(rsp_done == 1'b0, "R1 done in reset", 128'(rsp_done), 128'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 128'(req_ready), 128'h1);

      run(32'h0000_1000, 2'b00, 2'd0, 1'b1, 1'b0, pat, 1'b0);          // R4 word to 8-bit, no burst
      run(32'h0000_2000, 2'b00, 2'd0, 1'b1, 1'b1, pat, 1'b0);          // R3 word to 8-bit, burst
      run(32'h0000_3008, 2'b11, 2'd2, 1'b0, 1'b1, pat, 1'b0);          // R7 line wrap, 32-bit port
      run(32'h0000_4000, 2'b11, 2'd0, 1'b0, 1'b1, pat, 1'b0);          // R2 sixteen beats
      run(32'h0000_5002, 2'b10, 2'd2, 1'b0, 1'b1, pat, 1'b0);          // R8 single beat with burst enable
      run(32'h0000_6001, 2'b01, 2'd1, 1'b1, 1'b0, pat, 1'b0);          // R9 byte to 16-bit port
      run(32'h0000_7010, 2'b10, 2'd0, 1'b1, 1'b0, pat, 1'b1);          // R11 stray requests
      run(32'h0000_8106, 2'b11, 2'd1, 1'b0, 1'b0, pat, 1'b1);          // R4 R7 line, 16-bit, no burst
      run(32'h0000_9004, 2'b00, 2'd1, 1'b0, 1'b1, pat, 1'b0);          // R10 word read, 16-bit burst
      run(32'h0000_A00C, 2'b11, 2'd2, 1'b1, 1'b0, ~pat, 1'b0);         // R9 line write wrap

      repeat (2) @(negedge clk);
      chk(req_ready == 1'b1, "R11 no stray transfer", 128'(req_ready), 128'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule